// File: doc/BRIEF.md
# Pixel Hit Timer with ToT and ToA Event Selection

This block is the digital back end of a single detector pixel working in simultaneous mode. It watches one hit line and an active-low shutter. For the first hit inside the shutter window it records the arrival time (ToA). It also records the time over threshold (ToT) of the selected hits. The two counters advance on independent clock enables, so the pixel can use a coarse ToT tick and a fine ToA tick, or the other way round.

A mode input chooses how hits feed ToT. In first-hit mode, only the first pulse whose rising edge falls inside the open window is counted. In integral mode, every pulse whose rising edge falls inside the window is counted. A counted pulse that is still high when the shutter closes keeps counting until it falls or the counter reaches its ceiling. A fast clear zeroes both counters and re-arms the pixel for the next frame. A mask input freezes the pixel completely. A test input can take the place of the discriminator, to exercise the digital path on its own.

There is no valid/ready stream at this block's edge. The counter values are plain levels that a neighbouring readout chain samples when `busy_o` is low. Nothing here can stall, so the block has no back-pressure rule. The frame owner must wait for `busy_o` to fall after closing the shutter before it reads or clears the counters.

Top module: `pixel_hit_timer`

## Requirements
- R1: After reset, `tot_o` and `toa_o` are zero and `busy_o` is low.
- R2: A valid pulse adds one to `tot_o` for every clock with `tot_tick_i` high while the hit line is high. Counting starts with the clock that samples the rising edge. `busy_o` is high in the cycles after a counted sample while the pulse lasts.
- R3: With `integral_i` = 0 (first-hit), only the first pulse that rises inside the open window adds to `tot_o`.
- R4: With `integral_i` = 1, every pulse that rises inside the open window adds to `tot_o`.
- R5: A hit line that is already high when the window opens is not a hit. A hit is valid only if a rising edge is sampled while `shutter_n_i` = 0.
- R6: A counted pulse still high when `shutter_n_i` returns to 1 keeps adding to `tot_o` until it falls. A pulse that rises while the shutter is closed adds nothing.
- R7: `toa_o` counts the clocks with `toa_tick_i` high, from the window opening up to, but not including, the clock that samples the first rising edge in the window. After that clock, `toa_o` is frozen.
- R8: `toa_o` refers to the first hit in the window in both ToT modes. Later hits never change it.
- R9: Both counters stop at all ones and never wrap.
- R10: `fast_clear_i` = 1 zeroes both counters and `busy_o` on the next clock and re-arms first-hit detection. It takes priority over every other input.
- R11: While `mask_i` = 1, neither counter changes, `busy_o` stays low, and no hit is recorded.
- R12: With `test_en_i` = 1, `test_pulse_i` replaces `disc_i` as the hit line and `disc_i` is ignored.
- R13: `tot_o` changes only on clocks with `tot_tick_i` high. `toa_o` changes only on clocks with `toa_tick_i` high (a clear excepted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_i | input | 1 | Discriminator output |
| test_pulse_i | input | 1 | Digital test pulse |
| test_en_i | input | 1 | 1 selects the test pulse as the hit line |
| shutter_n_i | input | 1 | Shutter, window open while 0 |
| tot_tick_i | input | 1 | ToT count enable |
| toa_tick_i | input | 1 | ToA count enable |
| integral_i | input | 1 | 0 first-hit ToT, 1 integral ToT |
| mask_i | input | 1 | Freezes the pixel while 1 |
| fast_clear_i | input | 1 | Zeroes counters and re-arms |
| tot_o | output | TOT_W (10) | Time-over-threshold count |
| toa_o | output | TOA_W (18) | Time-of-arrival count |
| busy_o | output | 1 | A counted pulse is still in progress |

## Verification
A wrong "first hit seen" flag shows up in two ways. In first-hit mode, `tot_o` grows on a second pulse one clock after its rising edge. Otherwise `toa_o` keeps running past the hit on the next ToA tick. A stale "pulse active" flag shows as `busy_o` failing to drop the cycle after the line falls, and as ToT that follows a pulse which rose while the shutter was closed. A broken edge detector counts a line that was high before the window opened in the very first open cycle. A wrap instead of saturation appears as a counter that falls to zero one tick after all ones. The bench compares all three outputs with an independent model in every cycle, so each of these faults is reported within one clock of its first effect.

// File: rtl/pht_pkg.sv
package pht_pkg;
  localparam int unsigned TOT_W_DEF = 10;
  localparam int unsigned TOA_W_DEF = 18;

  // per-cycle commands from the hit selector to the two counters
  typedef struct packed {
    logic clr;
    logic tot_en;
    logic toa_en;
  } cnt_ctl_t;
endpackage

// File: rtl/pht_sat_counter.sv
module pht_sat_counter #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CEIL = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         at_ceil;

  assign at_ceil = (cnt_q == CEIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (en && !at_ceil)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R9: a full counter never rolls over
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (at_ceil && !clr) |=> (cnt_q == CEIL));
endmodule

// File: rtl/pht_hit_select.sv
module pht_hit_select
  import pht_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     disc_i,
  input  logic     test_pulse_i,
  input  logic     test_en_i,
  input  logic     shutter_n_i,
  input  logic     tot_tick_i,
  input  logic     toa_tick_i,
  input  logic     integral_i,
  input  logic     mask_i,
  input  logic     fast_clear_i,
  output cnt_ctl_t ctl_o,
  output logic     busy_o
);
  logic hit_line, hit_q, win_open, rise_in_win;
  logic seen_q, active_q, accept_rise, counting;

  assign hit_line    = test_en_i ? test_pulse_i : disc_i;
  assign win_open    = ~shutter_n_i;
  assign rise_in_win = hit_line & ~hit_q & win_open;
  assign accept_rise = rise_in_win & (integral_i | ~seen_q);
  assign counting    = hit_line & (active_q | accept_rise) & ~mask_i;

  always_comb begin
    ctl_o.clr    = fast_clear_i;
    ctl_o.tot_en = counting & tot_tick_i & ~fast_clear_i;
    ctl_o.toa_en = win_open & ~seen_q & ~rise_in_win & toa_tick_i
                 & ~mask_i & ~fast_clear_i;
  end

  // previous sample of the hit line, kept even while masked or clearing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      seen_q <= 1'b0;
    else if (fast_clear_i)           seen_q <= 1'b0;
    else if (!mask_i && rise_in_win) seen_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      active_q <= 1'b0;
    else if (fast_clear_i || mask_i) active_q <= 1'b0;
    else                             active_q <= counting;
  end

  assign busy_o = active_q;

  // R6: a pulse in progress ends the cycle after the line falls
  a_r6_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !hit_line) |=> !active_q);

  // R3: in first-hit mode an idle pixel that has seen its hit stays idle
  a_r3_first_only: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !integral_i && !active_q && !fast_clear_i) |=> !active_q);

  // R5: a line already high cannot start a pulse
  a_r5_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && hit_q && !fast_clear_i) |=> !active_q);
endmodule

// File: rtl/pixel_hit_timer.sv
module pixel_hit_timer
  import pht_pkg::*;
#(
  parameter int unsigned TOT_W = TOT_W_DEF,
  parameter int unsigned TOA_W = TOA_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disc_i,
  input  logic             test_pulse_i,
  input  logic             test_en_i,
  input  logic             shutter_n_i,
  input  logic             tot_tick_i,
  input  logic             toa_tick_i,
  input  logic             integral_i,
  input  logic             mask_i,
  input  logic             fast_clear_i,
  output logic [TOT_W-1:0] tot_o,
  output logic [TOA_W-1:0] toa_o,
  output logic             busy_o
);
  cnt_ctl_t ctl;

  pht_hit_select u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .disc_i       (disc_i),
    .test_pulse_i (test_pulse_i),
    .test_en_i    (test_en_i),
    .shutter_n_i  (shutter_n_i),
    .tot_tick_i   (tot_tick_i),
    .toa_tick_i   (toa_tick_i),
    .integral_i   (integral_i),
    .mask_i       (mask_i),
    .fast_clear_i (fast_clear_i),
    .ctl_o        (ctl),
    .busy_o       (busy_o)
  );

  pht_sat_counter #(.W(TOT_W)) u_tot (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctl.clr),
    .en    (ctl.tot_en),
    .cnt_o (tot_o)
  );

  pht_sat_counter #(.W(TOA_W)) u_toa (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctl.clr),
    .en    (ctl.toa_en),
    .cnt_o (toa_o)
  );

  // R10: clear wins over everything
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clear_i |=> (tot_o == '0) && (toa_o == '0) && !busy_o);

  // R11: a masked pixel is frozen
  a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i && !fast_clear_i) |=> $stable(tot_o) && $stable(toa_o) && !busy_o);

  // R13: each counter moves only on its own tick
  a_r13_tot_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!tot_tick_i && !fast_clear_i) |=> $stable(tot_o));
  a_r13_toa_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!toa_tick_i && !fast_clear_i) |=> $stable(toa_o));

  // R7: once a pulse is counting, the arrival time is fixed
  a_r7_toa_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fast_clear_i) |=> $stable(toa_o));

  // R2: ToT advances by at most one per clock
  a_r2_tot_step: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_clear_i |=> (tot_o == $past(tot_o)) || (tot_o == $past(tot_o) + 1'b1));
endmodule

// File: tb/pixel_hit_timer_bench.sv
module pixel_hit_timer_bench;
  localparam int TW = 6;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic disc = 0, tp = 0, ten = 0, shn = 1, tott = 0, toat = 0;
  logic integ = 0, mask = 0, fclr = 0;
  logic [TW-1:0] tot;
  logic [AW-1:0] toa;
  logic busy;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int m_tot = 0, m_toa = 0;
  bit m_seen = 0, m_act = 0, m_srcq = 0;

  pixel_hit_timer #(.TOT_W(TW), .TOA_W(AW)) u_pixel_hit_timer (
    .clk(clk), .rst_n(rst_n), .disc_i(disc), .test_pulse_i(tp),
    .test_en_i(ten), .shutter_n_i(shn), .tot_tick_i(tott),
    .toa_tick_i(toat), .integral_i(integ), .mask_i(mask),
    .fast_clear_i(fclr), .tot_o(tot), .toa_o(toa), .busy_o(busy)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int sat_inc(int v, int w);
    return (v == (1 << w) - 1) ? v : v + 1;
  endfunction

  // reference model, written from the requirements
  task automatic model_step();
    bit src, open, rise, take, cnt;
    src  = ten ? tp : disc;                       // R12
    open = !shn;
    rise = src && !m_srcq && open;                // R5
    if (fclr) begin                               // R10
      m_tot = 0; m_toa = 0; m_seen = 0; m_act = 0;
    end else if (mask) begin                      // R11
      m_act = 0;
    end else begin
      take = rise && (integ || !m_seen);          // R3 R4
      cnt  = src && (m_act || take);              // R2 R6
      if (cnt && tott) m_tot = sat_inc(m_tot, TW);
      if (open && !m_seen && !rise && toat) m_toa = sat_inc(m_toa, AW); // R7 R8
      m_act = cnt;
      if (rise) m_seen = 1;
    end
    m_srcq = src;
  endtask

  task automatic tick(string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(req, "tot", int'(tot), m_tot);
    chk(req, "toa", int'(toa), m_toa);
    chk(req, "busy", int'(busy), int'(m_act));
  endtask

  task automatic run(int n, string req);
    repeat (n) tick(req);
  endtask

  task automatic new_frame();
    shn = 1; disc = 0; tp = 0; mask = 0; ten = 0;
    tick("R10");
    fclr = 1; tick("R10");
    fclr = 0;
    chk("R10", "tot cleared", int'(tot), 0);
    chk("R10", "toa cleared", int'(toa), 0);
    tott = 1; toat = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", "tot reset", int'(tot), 0);
    chk("R1", "toa reset", int'(toa), 0);
    chk("R1", "busy reset", int'(busy), 0);
    rst_n = 1;
    run(2, "R1");

    // first-hit: timing and second pulse ignored
    new_frame(); integ = 0;
    shn = 0; run(5, "R7");
    disc = 1; run(4, "R2");
    disc = 0; run(2, "R2");
    chk("R7", "toa first hit", int'(toa), 5);
    chk("R2", "tot first pulse", int'(tot), 4);
    disc = 1; run(3, "R3");
    disc = 0; run(1, "R3");
    chk("R3", "tot second pulse ignored", int'(tot), 4);
    chk("R8", "toa unchanged", int'(toa), 5);

    // integral mode
    new_frame(); integ = 1;
    shn = 0; run(2, "R4");
    disc = 1; run(4, "R4"); disc = 0; run(2, "R4");
    disc = 1; run(3, "R4"); disc = 0; run(1, "R4");
    chk("R4", "tot integral", int'(tot), 7);
    chk("R8", "toa first in integral", int'(toa), 2);

    // line already high at window opening
    new_frame(); integ = 0;
    disc = 1; run(1, "R5");
    shn = 0; run(3, "R5");
    chk("R5", "no hit on high line", int'(tot), 0);
    disc = 0; run(1, "R5");
    disc = 1; run(2, "R5"); disc = 0; run(1, "R5");
    chk("R5", "tot after real edge", int'(tot), 2);
    chk("R5", "toa after real edge", int'(toa), 4);

    // pulse across shutter close, then a pulse after close
    new_frame(); integ = 1;
    shn = 0; disc = 1; run(2, "R6");
    shn = 1; run(3, "R6");
    chk("R6", "busy after close", int'(busy), 1);
    disc = 0; run(1, "R6");
    chk("R6", "tot across close", int'(tot), 5);
    disc = 1; run(2, "R6"); disc = 0; run(1, "R6");
    chk("R6", "closed pulse ignored", int'(tot), 5);

    // saturation
    new_frame(); integ = 0;
    shn = 0; run(300, "R9");
    chk("R9", "toa saturates", int'(toa), (1 << AW) - 1);
    disc = 1; run(80, "R9"); disc = 0; run(1, "R9");
    chk("R9", "tot saturates", int'(tot), (1 << TW) - 1);

    // mask
    new_frame(); mask = 1;
    shn = 0; run(3, "R11");
    disc = 1; run(3, "R11"); disc = 0; run(1, "R11");
    chk("R11", "masked tot", int'(tot), 0);
    chk("R11", "masked toa", int'(toa), 0);

    // test pulse path
    new_frame(); ten = 1;
    shn = 0; disc = 1; run(3, "R12"); disc = 0; run(1, "R12");
    chk("R12", "disc ignored", int'(tot), 0);
    tp = 1; run(2, "R12"); tp = 0; run(1, "R12");
    chk("R12", "test pulse tot", int'(tot), 2);
    chk("R12", "test pulse toa", int'(toa), 4);

    // separate ticks
    new_frame(); toat = 0;
    shn = 0; run(3, "R13");
    disc = 1;
    for (int i = 0; i < 10; i++) begin tott = i[0]; tick("R13"); end
    disc = 0; tick("R13");
    chk("R13", "tot half ticks", int'(tot), 5);
    chk("R13", "toa no ticks", int'(toa), 0);

    // clear in the middle of a pulse
    new_frame();
    shn = 0; disc = 1; run(3, "R10");
    fclr = 1; tick("R10"); fclr = 0;
    chk("R10", "busy cleared", int'(busy), 0);
    run(2, "R10");
    chk("R10", "no restart on high line", int'(tot), 0);

    // random mix
    new_frame();
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(5) == 0) disc = ~disc;
      if ($urandom_range(5) == 0) tp = ~tp;
      if ($urandom_range(39) == 0) shn = ~shn;
      if ($urandom_range(199) == 0) integ = ~integ;
      if ($urandom_range(299) == 0) ten = ~ten;
      tott = ($urandom_range(3) != 0);
      toat = ($urandom_range(3) != 0);
      mask = ($urandom_range(49) == 0);
      fclr = ($urandom_range(99) == 0);
      tick(integ ? "R4" : "R3");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule